// File: doc/BRIEF.md
# Pulse and Sawtooth Sound Generator

This block is an expansion sound source. It has two pulse voices and one sawtooth voice. Each voice is set up through three byte registers on a simple write port. On every clock each voice produces a small digital level. The three levels are added together.

The sum goes out on an amplitude port, which a global output-enable input can silence. The same sum is also presented, scaled by four, on a readback byte, so that software can sample the live level whether or not audio is enabled. Mixing in the analog domain, filtering and conversion happen outside this block.

Top module: `psaw_sound`

## Requirements
- R1: After reset all nine registers, counters, duty steps and the sawtooth accumulator are zero, so `level_read` and `mix_out` are both zero.
- R2: Write addresses 0 to 2 configure pulse voice A, addresses 3 to 5 configure pulse voice B, and addresses 6 to 8 configure the sawtooth voice. Writes to addresses 9 to 15 change nothing.
- R3: A pulse voice's period is {third register bits 3:0, second register}. On each clock where the voice is enabled and its counter is at most 1, the counter reloads with period+1 and a 4-bit duty step increments, wrapping from 15 to 0. Otherwise an enabled counter decrements. The first enabled clock after reset is an expiry.
- R4: An enabled pulse voice outputs the volume in bits 3:0 of its first register when either bit 7 of that register (forced output) is set or its duty step is greater than the duty in bits 6:4. Otherwise it outputs zero.
- R5: A voice whose enable (bit 7 of its third register) is clear contributes zero, and its counter, step and accumulator hold their values.
- R6: The sawtooth voice uses the same period and expiry rule on registers 7 and 8. An expiry index counts 0 to 13. Each expiry at an odd index below 13 adds the rate in bits 5:0 of register 6 to an 8-bit accumulator, which wraps. The expiry at index 13 clears the accumulator and the index.
- R7: The sawtooth level is accumulator bits 7:3 while the voice is enabled.
- R8: `level_read` equals the sum of the three voice levels, masked to 6 bits, with two zero bits appended below it. This holds regardless of `out_en`.
- R9: `mix_out` equals the 6-bit masked sum while `out_en` is high, and is zero while it is low.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| out_en | input | 1 | Global audio output enable |
| mix_out | output | 6 | Gated sum of the voice levels |
| level_read | output | 8 | Readback of the level sum shifted left by 2 |

## Verification
The following are checked on every cycle:
- An enabled counter either decrements or reloads and advances its step.
- A disabled voice keeps its step.
- The sawtooth accumulator is zero after the closing expiry.
- `mix_out` tracks `level_read` or stays silent, as `out_en` selects.

The bench is needed for the following:
- The exact volume pattern across duty, force and period settings.
- Sawtooth ramps for every rate.
- Writes at addresses above 8 having no effect.
- Voices resuming from held state after being re-enabled.

// File: rtl/psaw_sound.sv
module psaw_sound #(
  parameter int SAW_SLOTS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       out_en,
  output logic [5:0] mix_out,
  output logic [7:0] level_read
);
  localparam int PER_W = 12;
  localparam int CNT_W = PER_W + 1;
  localparam int E_W   = $clog2(2 * SAW_SLOTS);
  localparam logic [E_W-1:0] E_LAST = E_W'(2 * SAW_SLOTS - 1);

  logic [8:0][7:0]       rg;
  logic [1:0]            p_en;
  logic [1:0][CNT_W-1:0] p_cnt;
  logic [1:0][3:0]       p_step;
  logic [1:0][3:0]       p_lvl;
  logic                  s_en;
  logic [CNT_W-1:0]      s_cnt;
  logic [E_W-1:0]        s_e;
  logic [7:0]            s_acc;
  logic [4:0]            s_lvl;
  logic [6:0]            sum;

  always_ff @(posedge clk) begin
    if (!rst_n) rg <= '0;
    else if (wr_en && wr_addr < 4'd9) rg[wr_addr] <= wr_data;
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      p_en[c]  = rg[3*c+2][7];
      p_lvl[c] = 4'd0;
      if (p_en[c] && (rg[3*c][7] || p_step[c] > {1'b0, rg[3*c][6:4]}))
        p_lvl[c] = rg[3*c][3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_cnt  <= '0;
      p_step <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (p_en[c]) begin
          if (p_cnt[c] <= CNT_W'(1)) begin
            p_cnt[c]  <= {1'b0, rg[3*c+2][3:0], rg[3*c+1]} + CNT_W'(1);
            p_step[c] <= p_step[c] + 4'd1;
          end else begin
            p_cnt[c] <= p_cnt[c] - CNT_W'(1);
          end
        end
      end
    end
  end

  assign s_en = rg[8][7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cnt <= '0;
      s_e   <= '0;
      s_acc <= '0;
    end else if (s_en) begin
      if (s_cnt <= CNT_W'(1)) begin
        s_cnt <= {1'b0, rg[8][3:0], rg[7]} + CNT_W'(1);
        if (s_e == E_LAST) begin
          s_e   <= '0;
          s_acc <= '0;
        end else begin
          s_e <= s_e + E_W'(1);
          if (s_e[0]) s_acc <= s_acc + {2'b00, rg[6][5:0]};
        end
      end else begin
        s_cnt <= s_cnt - CNT_W'(1);
      end
    end
  end

  assign s_lvl      = s_en ? s_acc[7:3] : 5'd0;
  assign sum        = {3'b000, p_lvl[0]} + {3'b000, p_lvl[1]} + {2'b00, s_lvl};
  assign level_read = {sum[5:0], 2'b00};
  assign mix_out    = out_en ? sum[5:0] : 6'd0;
endmodule

// File: rtl/psaw_sound_chk.sv
module psaw_sound_chk #(
  parameter int CNT_W  = 13,
  parameter int E_W    = 4,
  parameter int E_LAST = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  out_en,
  input logic [5:0]            mix_out,
  input logic [7:0]            level_read,
  input logic [1:0]            p_en,
  input logic [1:0][CNT_W-1:0] p_cnt,
  input logic [1:0][3:0]       p_step,
  input logic                  s_en,
  input logic [CNT_W-1:0]      s_cnt,
  input logic [E_W-1:0]        s_e,
  input logic [7:0]            s_acc
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    a_r3_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (p_en[c] && p_cnt[c] <= CNT_W'(1)) |=> p_step[c] == $past(p_step[c]) + 4'd1);
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (p_en[c] && p_cnt[c] > CNT_W'(1)) |=> p_cnt[c] == $past(p_cnt[c]) - CNT_W'(1));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !p_en[c] |=> $stable(p_step[c]) && $stable(p_cnt[c]));
  end

  a_r6_saw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && s_cnt <= CNT_W'(1) && s_e == E_W'(E_LAST)) |=> s_acc == 8'd0 && s_e == '0);

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mix_out == (out_en ? level_read[7:2] : 6'd0));
endmodule

bind psaw_sound psaw_sound_chk #(.CNT_W(CNT_W), .E_W(E_W), .E_LAST(2 * SAW_SLOTS - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .mix_out(mix_out), .level_read(level_read),
  .p_en(p_en), .p_cnt(p_cnt), .p_step(p_step), .s_en(s_en), .s_cnt(s_cnt), .s_e(s_e),
  .s_acc(s_acc)
);

// File: tb/test_psaw_sound.sv
module test_psaw_sound;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic       out_en = 1'b1;
  logic [5:0] mix_out;
  logic [7:0] level_read;

  int checks = 0;
  int errors = 0;

  int mreg [9];
  int mcnt [3];
  int mstep [2];
  int me, macc;

  always #2 clk = ~clk;

  psaw_sound i_psaw_sound (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_en(out_en), .mix_out(mix_out), .level_read(level_read)
  );

  function automatic int lvl_p(int c);
    int r0 = mreg[3*c];
    if ((mreg[3*c+2] & 8'h80) == 0) return 0;
    if ((r0 & 8'h80) != 0 || mstep[c] > ((r0 >> 4) & 7)) return r0 & 15;
    return 0;
  endfunction

  function automatic int exp_sum();
    int s = lvl_p(0) + lvl_p(1);
    if ((mreg[8] & 8'h80) != 0) s += macc >> 3;
    return s & 63;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 9; i++) mreg[i] = 0;
    for (int i = 0; i < 3; i++) mcnt[i] = 0;
    mstep[0] = 0; mstep[1] = 0; me = 0; macc = 0;
  endtask

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      if ((mreg[3*c+2] & 8'h80) != 0) begin
        if (mcnt[c] <= 1) begin
          mcnt[c] = (((mreg[3*c+2] & 15) << 8) | mreg[3*c+1]) + 1;
          mstep[c] = (mstep[c] + 1) & 15;
        end else mcnt[c]--;
      end
    end
    if ((mreg[8] & 8'h80) != 0) begin
      if (mcnt[2] <= 1) begin
        mcnt[2] = (((mreg[8] & 15) << 8) | mreg[7]) + 1;
        if (me == 13) begin me = 0; macc = 0; end
        else begin
          if ((me & 1) != 0) macc = (macc + (mreg[6] & 63)) & 255;
          me++;
        end
      end else mcnt[2]--;
    end
    if (wr_en && wr_addr < 9) mreg[wr_addr] = wr_data;
  endtask

  task automatic check(string tag);
    int s = exp_sum();
    int er = s << 2;
    int em = out_en ? s : 0;
    checks++;
    if (level_read !== er[7:0]) begin
      errors++;
      $display("FAIL %s level_read actual=%0d expected=%0d", tag, level_read, er);
    end
    checks++;
    if (mix_out !== em[5:0]) begin
      errors++;
      $display("FAIL %s mix_out actual=%0d expected=%0d", tag, mix_out, em);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 1'b0;
    check(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(int a, int d, string tag);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
    tick(tag);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset");

    // R3 R4: both pulse voices, every duty with and without force, several periods
    for (int c = 0; c < 2; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int d = 0; d < 8; d++) begin
          wr(3*c, (f << 7) | (d << 4) | (15 - d), "R4 pulse setup");
          wr(3*c+1, d % 3, "R3 period");
          wr(3*c+2, 8'h80, "R3 enable");
          run(60, "R4 duty pattern");
        end
      end
      wr(3*c+2, 0, "R5 disable");
      run(8, "R5 disabled zero");
    end

    // R3: longer period with high nibble
    wr(0, 8'h3C, "R3 setup");
    wr(1, 8'h05, "R3 period lo");
    wr(2, 8'h81, "R3 period hi");
    run(300, "R3 long period");

    // R5: disable mid-run and resume from held state
    wr(2, 8'h01, "R5 pause");
    run(40, "R5 held");
    wr(2, 8'h81, "R5 resume");
    run(100, "R5 resumed");
    wr(2, 0, "R5 off");

    // R6 R7: sweep every saw rate
    wr(7, 0, "R6 period");
    wr(8, 8'h80, "R6 enable");
    for (int r = 0; r < 64; r++) begin
      wr(6, r, "R6 rate");
      run(40, "R7 saw ramp");
    end
    wr(7, 2, "R6 period 3");
    run(90, "R6 slower ramp");

    // R8: all voices together, sum large
    wr(0, 8'h8F, "R8 setup");
    wr(2, 8'h80, "R8 setup");
    wr(3, 8'h8F, "R8 setup");
    wr(5, 8'h80, "R8 setup");
    wr(6, 8'h3F, "R8 setup");
    run(80, "R8 sum readback");

    // R2: writes above the map are ignored
    for (int a = 9; a < 16; a++) begin
      wr(a, 8'h00, "R2 ignored write");
      run(3, "R2 unchanged");
    end

    // R9: output gating, readback unaffected
    for (int k = 0; k < 6; k++) begin
      out_en = k[0];
      run(15, "R9 gate");
    end
    out_en = 1'b1;

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset again");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule